// File: doc/BRIEF.md
# Wide Local Data Store Broadcast Unit

This block sits between a word-wide main memory and four SIMD lanes. It keeps a small local data store with one 32-bit entry per lane. Commands move words between memory and single entries, fan one memory word out to every entry, and exchange data between the entries and the lanes' register files. A broadcast command copies one entry into the same register of every lane. The block also computes addresses for indexed access: the selected entry number also picks the lane whose two registers are added to form the address.

The 1024-word memory is held inside the block. Each command arrives as an operation code plus operand fields, and no instruction decoding takes place here. The lanes' register files stay outside the block. The block receives each lane's values of the registers named by `cmd_ra` and `cmd_rb` combinationally, and it issues registered write strobes back to the lanes. A command is taken on a rising edge where `cmd_valid` is high and `busy` is low.

Top module: `ldsb_unit`

## Requirements
- R1: While reset is asserted (`rst_n` low) and after it is released, all store entries read zero and `busy`, `done` and `lane_we` are low.
- R2: Op code 0 (single load) reads memory at `cmd_addr` and writes entry `cmd_ls`. The other entries keep their values.
- R3: Op code 1 (single store) writes entry `cmd_ls` to memory at `cmd_addr`. `done` is high in the cycle after the accepting edge.
- R4: Op code 2 (wide load) writes the one word at `cmd_addr` into all four entries.
- R5: Op code 3 (entries to lanes) raises all `lane_we` bits for one cycle after the accepting edge, with `lane_widx` equal to `cmd_ra`. Lane k receives entry k in bits [32k+31:32k] of `lane_wdata`.
- R6: Op code 4 (lanes to entries) sets each entry k to lane k's register `cmd_ra` (bits [32k+31:32k] of `lane_rd_a`). No other command changes an entry on the edge at which it is accepted.
- R7: Op code 5 (broadcast) drives entry `cmd_ls` on every lane of `lane_wdata`, with all `lane_we` bits high and `lane_widx` equal to `cmd_ra`.
- R8: Op code 6 (indexed load) writes entry `cmd_ls` from the memory address given by the low 10 bits of lane `cmd_ls`'s `cmd_ra` register plus its `cmd_rb` register. Any carry beyond those 10 bits is dropped.
- R9: Op code 7 (indexed store) writes entry `cmd_ls` to memory at the address formed as in R8.
- R10: A load (op 0, 2 or 6) holds `busy` high for exactly one cycle after the accepting edge. Its entry update and a one-cycle `done` pulse then appear together one edge later. Every other command pulses `done` in the cycle right after its accepting edge.
- R11: A command presented while `busy` is high is ignored. It makes no memory write, no entry change and no lane write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Operation code (0..7, see requirements) |
| cmd_ls | input | 2 | Store entry / lane select |
| cmd_ra | input | 5 | First lane register number |
| cmd_rb | input | 5 | Second lane register number |
| cmd_addr | input | 10 | Direct memory word address |
| lane_rd_a | input | 128 | Each lane's register `cmd_ra`, lane k in bits [32k+31:32k] |
| lane_rd_b | input | 128 | Each lane's register `cmd_rb`, same packing |
| busy | output | 1 | Load in flight; commands are ignored |
| done | output | 1 | One-cycle completion pulse |
| lane_we | output | 4 | Per-lane register write strobe |
| lane_widx | output | 5 | Register number for the lane write |
| lane_wdata | output | 128 | Per-lane write data, lane k in bits [32k+31:32k] |
| entry_data | output | 128 | Current store entries, entry k in bits [32k+31:32k] |

## Verification
The checker assumes the lane read buses reflect registers `cmd_ra` and `cmd_rb` within the same cycle. It also assumes the operation code is always one of the eight defined values. The bench satisfies both with a combinational lane register model indexed directly by the command fields, and it only ever drives codes 0 to 7. The properties on `busy` and `done` assume a load is never followed by a command the block must accept during its wait cycle. The bench deliberately holds a command across that cycle only to show that the command is dropped. All inputs change on the falling edge, so every command field is stable at the accepting edge.

// File: rtl/ldsb_pkg.sv
package ldsb_pkg;

    typedef enum logic [2:0] {
        OP_LD_ONE  = 3'd0,
        OP_ST_ONE  = 3'd1,
        OP_LD_WIDE = 3'd2,
        OP_TO_LANE = 3'd3,
        OP_FR_LANE = 3'd4,
        OP_BCAST   = 3'd5,
        OP_LD_IDX  = 3'd6,
        OP_ST_IDX  = 3'd7
    } ldsb_op_e;

    function automatic logic is_load(input logic [2:0] op);
        return (op == OP_LD_ONE) || (op == OP_LD_WIDE) || (op == OP_LD_IDX);
    endfunction

endpackage

// File: rtl/ldsb_mem.sv
module ldsb_mem #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] words_q [DEPTH];
    logic [DATA_W-1:0] rd_data_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data_q <= words_q[rd_addr];
        end
    end

    assign rd_data = rd_data_q;

endmodule

// File: rtl/ldsb_lane_mux.sv
module ldsb_lane_mux #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [SEL_W-1:0]        sel,
    input  logic [LANES*DATA_W-1:0] vec,
    output logic [DATA_W-1:0]       pick
);
    logic [DATA_W-1:0] slot [LANES];

    for (genvar k = 0; k < LANES; k++) begin : g_slot
        assign slot[k] = vec[k*DATA_W +: DATA_W];
    end

    always_comb begin
        pick = '0;
        for (int k = 0; k < LANES; k++) begin
            if (sel == SEL_W'(k)) begin
                pick = slot[k];
            end
        end
    end

endmodule

// File: rtl/ldsb_idx_addr.sv
module ldsb_idx_addr #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [SEL_W-1:0]        lane_sel,
    input  logic [LANES*DATA_W-1:0] base_vec,
    input  logic [LANES*DATA_W-1:0] offs_vec,
    output logic [ADDR_W-1:0]       addr
);
    logic [DATA_W-1:0] base_w;
    logic [DATA_W-1:0] offs_w;
    logic [DATA_W-1:0] sum_w;

    ldsb_lane_mux #(.LANES(LANES), .DATA_W(DATA_W)) u_base (
        .sel  (lane_sel),
        .vec  (base_vec),
        .pick (base_w)
    );

    ldsb_lane_mux #(.LANES(LANES), .DATA_W(DATA_W)) u_offs (
        .sel  (lane_sel),
        .vec  (offs_vec),
        .pick (offs_w)
    );

    assign sum_w = base_w + offs_w;
    assign addr  = sum_w[ADDR_W-1:0];

endmodule

// File: rtl/ldsb_unit.sv
module ldsb_unit #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 10,
    parameter int REG_W  = 5,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int VEC_W = LANES * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [SEL_W-1:0]  cmd_ls,
    input  logic [REG_W-1:0]  cmd_ra,
    input  logic [REG_W-1:0]  cmd_rb,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [VEC_W-1:0]  lane_rd_a,
    input  logic [VEC_W-1:0]  lane_rd_b,
    output logic              busy,
    output logic              done,
    output logic [LANES-1:0]  lane_we,
    output logic [REG_W-1:0]  lane_widx,
    output logic [VEC_W-1:0]  lane_wdata,
    output logic [VEC_W-1:0]  entry_data
);
    import ldsb_pkg::*;

    typedef struct packed {
        logic             pend;
        logic             wide;
        logic [SEL_W-1:0] pls;
        logic [VEC_W-1:0] ent;
        logic             done;
        logic [LANES-1:0] we;
        logic [REG_W-1:0] widx;
        logic [VEC_W-1:0] wdata;
    } unit_state_t;

    unit_state_t st_d, st_q;

    logic              take;
    logic              mem_we, mem_re;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;
    logic [ADDR_W-1:0] idx_addr;
    logic [DATA_W-1:0] sel_entry;

    ldsb_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (mem_waddr),
        .wr_data (mem_wdata),
        .rd_en   (mem_re),
        .rd_addr (mem_raddr),
        .rd_data (mem_rdata)
    );

    ldsb_idx_addr #(.LANES(LANES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_idx (
        .lane_sel (cmd_ls),
        .base_vec (lane_rd_a),
        .offs_vec (lane_rd_b),
        .addr     (idx_addr)
    );

    ldsb_lane_mux #(.LANES(LANES), .DATA_W(DATA_W)) u_entry_pick (
        .sel  (cmd_ls),
        .vec  (st_q.ent),
        .pick (sel_entry)
    );

    assign take = cmd_valid && !st_q.pend;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.we   = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_waddr = cmd_addr;
        mem_raddr = cmd_addr;
        mem_wdata = sel_entry;

        if (st_q.pend) begin
            for (int k = 0; k < LANES; k++) begin
                if (st_q.wide || (st_q.pls == SEL_W'(k))) begin
                    st_d.ent[k*DATA_W +: DATA_W] = mem_rdata;
                end
            end
            st_d.pend = 1'b0;
            st_d.done = 1'b1;
        end else if (take) begin
            unique case (ldsb_op_e'(cmd_op))
                OP_LD_ONE: begin
                    mem_re    = 1'b1;
                    st_d.pend = 1'b1;
                    st_d.wide = 1'b0;
                    st_d.pls  = cmd_ls;
                end
                OP_LD_WIDE: begin
                    mem_re    = 1'b1;
                    st_d.pend = 1'b1;
                    st_d.wide = 1'b1;
                    st_d.pls  = cmd_ls;
                end
                OP_LD_IDX: begin
                    mem_re    = 1'b1;
                    mem_raddr = idx_addr;
                    st_d.pend = 1'b1;
                    st_d.wide = 1'b0;
                    st_d.pls  = cmd_ls;
                end
                OP_ST_ONE: begin
                    mem_we    = 1'b1;
                    st_d.done = 1'b1;
                end
                OP_ST_IDX: begin
                    mem_we    = 1'b1;
                    mem_waddr = idx_addr;
                    st_d.done = 1'b1;
                end
                OP_TO_LANE: begin
                    st_d.we    = '1;
                    st_d.widx  = cmd_ra;
                    st_d.wdata = st_q.ent;
                    st_d.done  = 1'b1;
                end
                OP_BCAST: begin
                    st_d.we    = '1;
                    st_d.widx  = cmd_ra;
                    st_d.wdata = {LANES{sel_entry}};
                    st_d.done  = 1'b1;
                end
                OP_FR_LANE: begin
                    st_d.ent  = lane_rd_a;
                    st_d.done = 1'b1;
                end
                default: begin
                    st_d.done = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy       = st_q.pend;
    assign done       = st_q.done;
    assign lane_we    = st_q.we;
    assign lane_widx  = st_q.widx;
    assign lane_wdata = st_q.wdata;
    assign entry_data = st_q.ent;

endmodule

// File: rtl/ldsb_checker.sv
module ldsb_checker #(
    parameter int LANES  = 4,
    parameter int DATA_W = 32,
    parameter int REG_W  = 5,
    localparam int VEC_W = LANES * DATA_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_op,
    input logic [REG_W-1:0] cmd_ra,
    input logic             busy,
    input logic             done,
    input logic [LANES-1:0] lane_we,
    input logic [REG_W-1:0] lane_widx,
    input logic [VEC_W-1:0] lane_wdata,
    input logic [VEC_W-1:0] entry_data
);
    import ldsb_pkg::*;

    logic accepted;
    logic wdata_uniform;

    assign accepted = cmd_valid && !busy;

    always_comb begin
        wdata_uniform = 1'b1;
        for (int k = 1; k < LANES; k++) begin
            if (lane_wdata[k*DATA_W +: DATA_W] != lane_wdata[DATA_W-1:0]) begin
                wdata_uniform = 1'b0;
            end
        end
    end

    AST_LOAD_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && is_load(cmd_op)) |=> busy); // R10

    AST_BUSY_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && done)); // R10

    AST_BUSY_NO_LANE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (lane_we == '0)); // R11

    AST_TO_LANE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && cmd_op == OP_TO_LANE) |=> ((&lane_we) && lane_widx == $past(cmd_ra))); // R5

    AST_BCAST_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && cmd_op == OP_BCAST) |=> ((&lane_we) && wdata_uniform)); // R7

    AST_ENTRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(cmd_valid && cmd_op == OP_FR_LANE)) |=> $stable(entry_data)); // R6

endmodule

bind ldsb_unit ldsb_checker #(
    .LANES  (LANES),
    .DATA_W (DATA_W),
    .REG_W  (REG_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_ra     (cmd_ra),
    .busy       (busy),
    .done       (done),
    .lane_we    (lane_we),
    .lane_widx  (lane_widx),
    .lane_wdata (lane_wdata),
    .entry_data (entry_data)
);

// File: tb/sim_ldsb_unit.sv
`timescale 1ns/1ps
module sim_ldsb_unit;
    localparam int LN = 4;
    localparam int DW = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic [2:0]   cmd_op = '0;
    logic [1:0]   cmd_ls = '0;
    logic [4:0]   cmd_ra = '0;
    logic [4:0]   cmd_rb = '0;
    logic [9:0]   cmd_addr = '0;
    logic [127:0] lane_rd_a, lane_rd_b;
    logic         busy, done;
    logic [3:0]   lane_we;
    logic [4:0]   lane_widx;
    logic [127:0] lane_wdata, entry_data;

    logic [31:0] lrf [LN][32];

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    ldsb_unit u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ls(cmd_ls), .cmd_ra(cmd_ra), .cmd_rb(cmd_rb), .cmd_addr(cmd_addr),
        .lane_rd_a(lane_rd_a), .lane_rd_b(lane_rd_b), .busy(busy), .done(done),
        .lane_we(lane_we), .lane_widx(lane_widx), .lane_wdata(lane_wdata),
        .entry_data(entry_data)
    );

    always_comb begin
        for (int k = 0; k < LN; k++) begin
            lane_rd_a[k*DW +: DW] = lrf[k][cmd_ra];
            lane_rd_b[k*DW +: DW] = lrf[k][cmd_rb];
        end
    end

    always @(posedge clk) begin
        for (int k = 0; k < LN; k++) begin
            if (lane_we[k]) lrf[k][lane_widx] <= lane_wdata[k*DW +: DW];
        end
    end

    // addr[41:32], data[31:0]
    localparam logic [41:0] VEC [8] = '{
        {10'd5,    32'h1234_5678}, {10'd17,   32'hDEAD_BEEF},
        {10'd1023, 32'h0000_0001}, {10'd0,    32'hFFFF_FFFF},
        {10'd512,  32'hA5A5_5A5A}, {10'd300,  32'h0F0F_F0F0},
        {10'd77,   32'h8000_0000}, {10'd900,  32'h1357_9BDF}
    };

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Issue one command; returns at the falling edge after the accepting edge.
    task automatic issue(input logic [2:0] op, input logic [1:0] ls, input logic [4:0] ra,
                         input logic [4:0] rb, input logic [9:0] ad);
        cmd_op = op; cmd_ls = ls; cmd_ra = ra; cmd_rb = rb; cmd_addr = ad;
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_lanes(input logic [4:0] r, input logic [31:0] base);
        for (int k = 0; k < LN; k++) lrf[k][r] = base + 32'(k);
    endtask

    function automatic logic [127:0] lane_vec(input logic [31:0] base);
        logic [127:0] v;
        for (int k = 0; k < LN; k++) v[k*DW +: DW] = base + 32'(k);
        return v;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
        finish_run();
    end

    initial begin
        logic [127:0] exp;
        logic [31:0]  w;
        for (int k = 0; k < LN; k++)
            for (int r = 0; r < 32; r++) lrf[k][r] = '0;

        @(negedge clk); @(negedge clk);
        // R1: state during reset
        chk(entry_data == '0 && !busy && !done && lane_we == '0, "R1 in reset",
            {entry_data[123:0], busy, done, lane_we[1:0]}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(entry_data == '0 && !busy && !done && lane_we == '0, "R1 after reset",
            {entry_data[123:0], busy, done, lane_we[1:0]}, '0);

        // Table walk: lanes->entries, single store, clear, single load
        for (int i = 0; i < 8; i++) begin
            logic [9:0]  ad;
            logic [31:0] dt;
            logic [1:0]  ls;
            ad = VEC[i][41:32]; dt = VEC[i][31:0]; ls = 2'(i);
            set_lanes(5'd1, dt);
            issue(3'd4, 2'd0, 5'd1, 5'd0, 10'd0);
            chk(entry_data == lane_vec(dt) && done, "R6 lanes to entries", entry_data, lane_vec(dt));
            issue(3'd1, ls, 5'd0, 5'd0, ad);
            chk(done == 1'b1, "R3 store done", 128'(done), 128'd1);
            issue(3'd4, 2'd0, 5'd0, 5'd0, 10'd0); // r0 is zero in every lane
            issue(3'd0, ls, 5'd0, 5'd0, ad);
            chk(busy && !done && entry_data == '0, "R10 load wait", {busy, done, entry_data[125:0]}, 128'd2 << 126);
            wait_cyc();
            exp = '0; exp[ls*DW +: DW] = dt + 32'(ls);
            chk(entry_data == exp, "R2 single load", entry_data, exp);
            chk(done && !busy, "R10 load done", 128'({done, busy}), 128'd2);
        end

        // R4: wide load of VEC[1] word (stored as data+1)
        issue(3'd2, 2'd3, 5'd0, 5'd0, 10'd17);
        wait_cyc();
        exp = {4{32'hDEAD_BEEF + 32'd1}};
        chk(entry_data == exp, "R4 wide load", entry_data, exp);

        // R6 ignored: a store command leaves entries untouched
        issue(3'd1, 2'd0, 5'd0, 5'd0, 10'd40);
        chk(entry_data == exp, "R6 entries unchanged by store", entry_data, exp);

        // R5: entries to lanes
        set_lanes(5'd2, 32'h0000_1000);
        issue(3'd4, 2'd0, 5'd2, 5'd0, 10'd0);
        issue(3'd3, 2'd0, 5'd7, 5'd0, 10'd0);
        chk(lane_we == 4'hF && lane_widx == 5'd7 && lane_wdata == lane_vec(32'h1000),
            "R5 entries to lanes", lane_wdata, lane_vec(32'h1000));
        wait_cyc();
        chk(lrf[3][7] == 32'h1003 && lane_we == '0, "R5 lane 3 written once",
            {lrf[3][7], lane_we}, {32'h1003, 4'h0});

        // R7: broadcast entry 2 into r9
        issue(3'd5, 2'd2, 5'd9, 5'd0, 10'd0);
        exp = {4{32'h0000_1002}};
        chk(lane_we == 4'hF && lane_widx == 5'd9 && lane_wdata == exp, "R7 broadcast", lane_wdata, exp);
        wait_cyc();
        chk(lrf[0][9] == 32'h1002, "R7 lane 0 got entry 2", lrf[0][9], 32'h1002);

        // R8: indexed load, lane 3 regs 4+5 = 1000+30 -> wraps to 6
        set_lanes(5'd3, 32'hCAFE_0000);
        issue(3'd4, 2'd0, 5'd3, 5'd0, 10'd0);
        issue(3'd1, 2'd1, 5'd0, 5'd0, 10'd6);            // M[6] = CAFE0001
        set_lanes(5'd2, 32'h0000_2000);
        issue(3'd4, 2'd0, 5'd2, 5'd0, 10'd0);            // entries 2000..2003
        for (int k = 0; k < LN; k++) begin lrf[k][4] = 32'd1; lrf[k][5] = 32'd1; end
        lrf[3][4] = 32'd1000; lrf[3][5] = 32'd30;
        issue(3'd6, 2'd3, 5'd4, 5'd5, 10'd0);
        wait_cyc();
        exp = lane_vec(32'h2000); exp[3*DW +: DW] = 32'hCAFE_0001;
        chk(entry_data == exp, "R8 indexed load wraps", entry_data, exp);

        // R9: indexed store, lane 1 regs 4+5 = 100+3 = 103
        lrf[1][4] = 32'd100; lrf[1][5] = 32'd3;
        issue(3'd7, 2'd1, 5'd4, 5'd5, 10'd0);            // M[103] = entry1 = 2001
        chk(done == 1'b1, "R9 indexed store done", 128'(done), 128'd1);
        issue(3'd0, 2'd0, 5'd0, 5'd0, 10'd103);
        wait_cyc();
        chk(entry_data[31:0] == 32'h2001, "R9 indexed store target", entry_data[31:0], 32'h2001);

        // R11: command held into the busy cycle is dropped
        set_lanes(5'd10, 32'h7777_0000);
        cmd_op = 3'd0; cmd_ls = 2'd2; cmd_addr = 10'd6; cmd_ra = 5'd0; cmd_rb = 5'd0;
        cmd_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        cmd_op = 3'd4; cmd_ra = 5'd10;                    // lanes->entries while busy
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        exp = lane_vec(32'h2000); exp[31:0] = 32'h2001; exp[3*DW +: DW] = 32'hCAFE_0001;
        exp[2*DW +: DW] = 32'hCAFE_0001;
        chk(entry_data == exp && lane_we == '0, "R11 busy command ignored", entry_data, exp);
        wait_cyc();
        chk(entry_data == exp, "R11 no late effect", entry_data, exp);

        // R1: reset clears entries again
        rst_n = 1'b0;
        wait_cyc();
        chk(entry_data == '0 && !done && !busy, "R1 reset clears", entry_data, '0);
        rst_n = 1'b1;
        wait_cyc();
        finish_run();
    end

endmodule